// File: doc/BRIEF.md
# Zero-Run Bit Expander

This block turns a stream of byte-sized codes into a serial configuration bitstream. Each code is one of two kinds. The most significant bit of the byte is a tag that selects the kind. A code with the tag clear expands to a run of zero bits. A code with the tag set carries seven raw bits that are sent unchanged.

Codes enter on a valid/ready handshake, and bits leave on a second valid/ready handshake, one bit per transfer. The block fetches the next code in the same cycle that the last bit of the current code is taken. A stream of codes therefore comes out with no idle cycles between them.

A flush input throws away whatever code is partly sent. A running count of the bits delivered lets the consumer compare the total length of a stream against the length it expects.

Top module: `zrun_expander`

## Requirements
- R1: After reset `bitValid` is 0, `codeReady` is 1 and `bitCount` is 0.
- R2: A code whose bit 7 is 0 produces exactly N+1 zero bits, where N is the value of bits 6..0. The shortest run (N=0) is 1 bit and the longest (N=127) is 128 bits.
- R3: A code whose bit 7 is 1 produces exactly seven bits equal to code bits 6..0. Bit 6 is sent first and bit 0 last.
- R4: In the cycle where the last bit of a code is transferred, `codeReady` is 1 (when `flush` is low). A waiting code is then taken in that same cycle, so output bits continue with no gap.
- R5: `bitValid` is 1 exactly while bits of an accepted code remain to be transferred, and 0 otherwise.
- R6: While `bitValid` is 1 and `bitReady` is 0, `bitValid` stays 1 and `bitData` keeps its value in the next cycle.
- R7: While `flush` is 1, `codeReady` and `bitValid` are 0. In the next cycle any partly sent code is gone and `bitCount` is 0.
- R8: `bitCount` grows by one for every bit transferred (`bitValid` and `bitReady` both 1) and holds otherwise. It wraps modulo 2^CNT_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Drop the current code and clear the bit count |
| codeValid | input | 1 | A code byte is offered |
| codeByte | input | PAY_W+1 | Code byte: tag in the top bit, payload below it |
| codeReady | output | 1 | The block takes the offered code this cycle |
| bitValid | output | 1 | An output bit is offered |
| bitData | output | 1 | The output bit |
| bitReady | input | 1 | The consumer takes the output bit this cycle |
| bitCount | output | CNT_W | Number of bits transferred since reset or the last flush |

## Verification
The assertions assume that `flush` is a clean synchronous level. They also assume that the consumer may stall `bitReady` for any length of time. They make no assumption that `codeValid` stays asserted until the code is taken, because the block samples a code only on a handshake.

The stimulus pulls codes from a queue and offers them with random gaps. It drops `bitReady` at random as well. Flush is applied only in a directed sequence, in the middle of a literal, and a fresh code is held on the input while flush is high.

// File: rtl/zrx_pkg.sv
package zrx_pkg;
  // Strobes from control to datapath, one cycle each
  typedef struct packed {
    logic load;     // capture a new code byte
    logic advance;  // step to the next bit of the current code
    logic take;     // one output bit transferred
    logic clear;    // flush request
  } zrxStrobe_t;
endpackage

// File: rtl/zrx_datapath.sv
module zrx_datapath
  import zrx_pkg::*;
#(
  parameter int PAY_W = 7,
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  zrxStrobe_t       strobe,
  input  logic [PAY_W:0]   codeByte,
  output logic             lastBit,
  output logic             bitData,
  output logic [CNT_W-1:0] bitCount
);
  // A literal sends PAY_W bits; the counter holds bits left minus one
  localparam logic [PAY_W-1:0] LIT_LAST = PAY_W'(PAY_W - 1);

  logic [PAY_W-1:0] remain;
  logic [PAY_W-1:0] shReg;
  logic             isLit;

  always_ff @(posedge clk) begin
    if (!rstN || strobe.clear) begin
      remain <= '0;
      shReg  <= '0;
      isLit  <= 1'b0;
    end else if (strobe.load) begin
      isLit  <= codeByte[PAY_W];
      shReg  <= codeByte[PAY_W-1:0];
      remain <= codeByte[PAY_W] ? LIT_LAST : codeByte[PAY_W-1:0];
    end else if (strobe.advance) begin
      remain <= remain - 1'b1;
      shReg  <= {shReg[PAY_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobe.clear) bitCount <= '0;
    else if (strobe.take)      bitCount <= bitCount + 1'b1;
  end

  assign lastBit = (remain == '0);
  assign bitData = isLit & shReg[PAY_W-1];
endmodule

// File: rtl/zrx_ctrl.sv
module zrx_ctrl
  import zrx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       flush,
  input  logic       codeValid,
  input  logic       bitReady,
  input  logic       lastBit,
  output logic       codeReady,
  output logic       bitValid,
  output zrxStrobe_t strobe
);
  logic active;
  logic take;
  logic finish;

  assign bitValid  = active & ~flush;
  assign take      = bitValid & bitReady;
  assign finish    = take & lastBit;
  assign codeReady = ~flush & (~active | finish);

  always_comb begin
    strobe.clear   = flush;
    strobe.take    = take;
    strobe.load    = codeValid & codeReady;
    strobe.advance = take & ~lastBit;
  end

  always_ff @(posedge clk) begin
    if (!rstN || flush)   active <= 1'b0;
    else if (strobe.load) active <= 1'b1;
    else if (finish)      active <= 1'b0;
  end
endmodule

// File: rtl/zrun_expander.sv
module zrun_expander
  import zrx_pkg::*;
#(
  parameter int PAY_W = 7,
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic             codeValid,
  input  logic [PAY_W:0]   codeByte,
  output logic             codeReady,
  output logic             bitValid,
  output logic             bitData,
  input  logic             bitReady,
  output logic [CNT_W-1:0] bitCount
);
  zrxStrobe_t strobe;
  logic       lastBit;

  zrx_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .flush     (flush),
    .codeValid (codeValid),
    .bitReady  (bitReady),
    .lastBit   (lastBit),
    .codeReady (codeReady),
    .bitValid  (bitValid),
    .strobe    (strobe)
  );

  zrx_datapath #(.PAY_W(PAY_W), .CNT_W(CNT_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .codeByte (codeByte),
    .lastBit  (lastBit),
    .bitData  (bitData),
    .bitCount (bitCount)
  );
endmodule

// File: rtl/zrx_checker.sv
module zrx_checker #(
  parameter int CNT_W = 24
) (
  input logic             clk,
  input logic             rstN,
  input logic             flush,
  input logic             codeValid,
  input logic             codeReady,
  input logic             bitValid,
  input logic             bitData,
  input logic             bitReady,
  input logic [CNT_W-1:0] bitCount
);
  a_r7_flush_blocks: assert property (@(posedge clk) disable iff (!rstN)
    flush |-> (!codeReady && !bitValid));

  a_r7_flush_clears: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> (!bitValid && bitCount == '0));

  a_r5_accept_valid: assert property (@(posedge clk) disable iff (!rstN)
    (codeValid && codeReady) |=> (bitValid || flush));

  a_r6_stall_hold: assert property (@(posedge clk) disable iff (!rstN)
    (bitValid && !bitReady) |=> (flush || (bitValid && $stable(bitData))));

  a_r8_count_step: assert property (@(posedge clk) disable iff (!rstN)
    (bitValid && bitReady) |=> (bitCount == $past(bitCount) + 1'b1));

  a_r8_count_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!bitValid && !flush) |=> $stable(bitCount));
endmodule

bind zrun_expander zrx_checker #(.CNT_W(CNT_W)) u_zrxChk (
  .clk       (clk),
  .rstN      (rstN),
  .flush     (flush),
  .codeValid (codeValid),
  .codeReady (codeReady),
  .bitValid  (bitValid),
  .bitData   (bitData),
  .bitReady  (bitReady),
  .bitCount  (bitCount)
);

// File: tb/tb_zrun_expander.sv
module tb_zrun_expander;
  localparam int PAY_W = 7;
  localparam int CNT_W = 24;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic flush = 1'b0;
  logic codeValid = 1'b0;
  logic [PAY_W:0] codeByte = '0;
  logic bitReady = 1'b0;
  logic codeReady, bitValid, bitData;
  logic [CNT_W-1:0] bitCount;

  int checks = 0;
  int errors = 0;
  int expCount = 0;
  bit expQ[$];
  logic [7:0] srcQ[$];
  bit prevStall = 0;
  bit prevData = 0;
  bit done = 0;

  always #4 clk = ~clk;

  zrun_expander #(.PAY_W(PAY_W), .CNT_W(CNT_W)) dut (
    .clk(clk), .rstN(rstN), .flush(flush), .codeValid(codeValid),
    .codeByte(codeByte), .codeReady(codeReady), .bitValid(bitValid),
    .bitData(bitData), .bitReady(bitReady), .bitCount(bitCount)
  );

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // expected expansion of one code (R2: zero run, R3: literal msb first)
  function automatic void pushCode(logic [7:0] c);
    if (c[7]) begin
      for (int i = 6; i >= 0; i--) expQ.push_back(c[i]);
    end else begin
      for (int i = 0; i <= int'(c[6:0]); i++) expQ.push_back(1'b0);
    end
  endfunction

  task automatic cycle(bit offer, bit br, bit fl);
    bit cv;
    bit fire;
    @(negedge clk);
    cv = offer && (srcQ.size() > 0);
    codeValid = cv;
    codeByte  = cv ? srcQ[0] : 8'($urandom);
    bitReady  = br;
    flush     = fl;
    #1;
    if (fl) begin
      chk(!codeReady, "R7", "codeReady in flush", codeReady, 0);
      chk(!bitValid, "R7", "bitValid in flush", bitValid, 0);
      expQ.delete();
      expCount  = 0;
      prevStall = 0;
    end else begin
      chk(bitValid == (expQ.size() > 0), "R5", "bitValid", bitValid, expQ.size() > 0);
      if (prevStall)
        chk(bitValid && bitData == prevData, "R6", "held bit", bitData, prevData);
      fire = bitValid && br && expQ.size() > 0;
      if (fire && expQ.size() == 1 && cv)
        chk(codeReady, "R4", "codeReady on last bit", codeReady, 1);
      if (fire) begin
        chk(bitData == expQ[0], "R2/R3", "bitData", bitData, expQ[0]);
        void'(expQ.pop_front());
        expCount++;
      end
      prevStall = bitValid && !br;
      prevData  = bitData;
      if (cv && codeReady) begin
        pushCode(srcQ[0]);
        void'(srcQ.pop_front());
      end
    end
  endtask

  task automatic run(int readyPct, int offerPct);
    int guard = 0;
    while ((srcQ.size() > 0 || expQ.size() > 0) && guard < 150000) begin
      cycle(($urandom % 100) < offerPct, ($urandom % 100) < readyPct, 1'b0);
      guard++;
    end
  endtask

  task automatic checkCount(string req);
    cycle(1'b0, 1'b0, 1'b0);
    chk(bitCount == expCount[CNT_W-1:0], req, "bitCount", bitCount, expCount);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R5 watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1 reset state
    chk(!bitValid, "R1", "bitValid", bitValid, 0);
    chk(codeReady, "R1", "codeReady", codeReady, 1);
    chk(bitCount == '0, "R1", "bitCount", bitCount, 0);

    // directed: shortest and longest runs, literals, back to back (R2 R3 R4)
    srcQ = '{8'h00, 8'h7F, 8'hFF, 8'h80, 8'hA5, 8'h01, 8'hC3, 8'h00};
    run(100, 100);
    checkCount("R8");

    // directed: stalls on a literal (R6)
    srcQ = '{8'hAA, 8'hD5};
    run(30, 100);
    checkCount("R8");

    // random codes with random gaps and backpressure
    for (int i = 0; i < 400; i++) begin
      logic [7:0] c;
      if ($urandom % 2) c = {1'b1, 7'($urandom)};
      else if ($urandom % 10 == 0) c = 8'h7F;
      else c = {1'b0, 7'($urandom % 32)};
      srcQ.push_back(c);
    end
    run(70, 80);
    checkCount("R8");

    // flush in the middle of a literal (R7)
    srcQ = '{8'hFF};
    cycle(1'b1, 1'b1, 1'b0);
    cycle(1'b0, 1'b1, 1'b0);
    cycle(1'b0, 1'b1, 1'b0);
    srcQ.push_back(8'h05);
    cycle(1'b1, 1'b1, 1'b1);
    cycle(1'b0, 1'b1, 1'b0);
    chk(bitCount == '0, "R7", "bitCount after flush", bitCount, 0);
    chk(srcQ.size() == 1, "R7", "code taken during flush", srcQ.size(), 1);
    run(100, 100);
    checkCount("R8");

    // more random traffic after flush
    for (int i = 0; i < 100; i++) srcQ.push_back(8'($urandom));
    run(50, 60);
    checkCount("R8");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule